// File: doc/BRIEF.md
# Serial Baud Tick Generator

This block supplies the timing events for a serial transmitter and receiver that share one configuration. From three control bits it decodes one of five clock modes. In the internal modes it counts system clock cycles and raises a tick at the end of every programmed period. In the external modes it turns transitions on a clock pin into ticks instead. An asynchronous engine uses sixteen ticks per bit, and a synchronous engine uses two ticks per bit, one for each clock phase.

The period counter runs freely from reset, so its phase follows the running cycle count. Ticks reach the output only while the transmitter or the receiver asks for them. When both are idle, no tick is produced. When one of them becomes active again, the first tick lands on the next period boundary of the running count, not on a freshly restarted countdown. The shift engines read the decoded mode code to learn whether to expect synchronous ticks and whether to drive a clock pin.

Top module: `baud_tick_gen`

## Requirements
- R1: `clk_mode` decodes the control bits as follows. With `sync_mode`=1, `cke1`=1 gives 4 (external synchronous) and `cke1`=0 gives 3 (internal synchronous with clock output). With `sync_mode`=0, `cke1`=1 gives 2 (external asynchronous), `cke0`=1 gives 1 (internal asynchronous with clock output), and anything else gives 0 (internal asynchronous). `cke1` takes precedence over `cke0`.
- R2: In internal modes (codes 0, 1 and 3) the period is P = 2 * 4^cks * (brr+1) system cycles. With the configuration held constant, a tick is high in the cycle after rising clock edge k (counted from reset release) exactly when k is a multiple of P and a request was active before that edge.
- R3: While `tx_active` and `rx_active` are both low, `tick` stays low. Ticks resume on the next multiple of P of the running count, with no restart of the count.
- R4: A change of `cks` or `brr` takes effect at the next period boundary. The boundary already scheduled keeps the old period, and the period that follows it uses the new value.
- R5: In external asynchronous mode, each rising edge of `ext_clk_in` gives exactly one tick, and falling edges give none. The tick is high in the cycle after the third rising clock edge that follows the pin change.
- R6: In external synchronous mode, each rising and each falling edge of `ext_clk_in` gives one tick, with the same latency as in R5.
- R7: In internal modes, `ext_clk_in` has no effect on `tick`. In external modes, the period counter produces no ticks.
- R8: `tick` is low during and right after reset. In internal modes it is never high for two consecutive cycles.
- R9: A request on either `tx_active` or `rx_active` alone is enough to enable ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cks | input | 2 | Prescaler select (factor 4^cks) |
| brr | input | 8 | Bit-rate divisor minus one |
| sync_mode | input | 1 | 1 selects synchronous framing |
| cke1 | input | 1 | Select external clock source |
| cke0 | input | 1 | Asynchronous clock output enable |
| ext_clk_in | input | 1 | External clock pin, asynchronous to clk |
| tx_active | input | 1 | Transmitter requests ticks |
| rx_active | input | 1 | Receiver requests ticks |
| tick | output | 1 | One-cycle tick strobe |
| clk_mode | output | 3 | Decoded clock mode code |

## Verification
If the period register or the phase counter goes wrong, every later tick shifts against the multiples of P. A bench that compares each cycle with a model based on the running count catches this at the first boundary after the fault, which is at most P cycles away. A fault in the synchronizer or the edge detector shows up as a missing, extra or late tick three cycles after a pin change. A wrong boundary rule for new configuration values moves the tick that follows the change, so the error is visible within one old period plus one new period.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic [2:0] {
        CM_INT_ASYNC     = 3'd0,
        CM_INT_ASYNC_OUT = 3'd1,
        CM_EXT_ASYNC     = 3'd2,
        CM_INT_SYNC_OUT  = 3'd3,
        CM_EXT_SYNC      = 3'd4
    } clk_mode_e;

    typedef struct packed {
        logic sync_mode;
        logic cke1;
        logic cke0;
    } clk_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    function automatic clk_mode_e decode_mode(clk_ctrl_t c);
        if (c.sync_mode)
            return c.cke1 ? CM_EXT_SYNC : CM_INT_SYNC_OUT;
        if (c.cke1)
            return CM_EXT_ASYNC;
        if (c.cke0)
            return CM_INT_ASYNC_OUT;
        return CM_INT_ASYNC;
    endfunction

    function automatic logic mode_internal(clk_mode_e m);
        return (m == CM_INT_ASYNC) || (m == CM_INT_ASYNC_OUT) || (m == CM_INT_SYNC_OUT);
    endfunction

    function automatic int unsigned period_cycles(int unsigned cks, int unsigned brr);
        return (32'd2 << (2 * cks)) * (brr + 32'd1);
    endfunction

endpackage

// File: rtl/baud_mode_decode.sv
module baud_mode_decode
    import baud_tick_pkg::*;
(
    input  clk_ctrl_t ctrl,
    output clk_mode_e mode,
    output logic      internal_src
);
    always_comb begin
        mode         = decode_mode(ctrl);
        internal_src = mode_internal(mode);
    end
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div
    import baud_tick_pkg::*;
#(
    parameter int CKS_W = 2,
    parameter int BRR_W = 8,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CKS_W-1:0] cks,
    input  logic [BRR_W-1:0] brr,
    output logic             wrap,
    output logic [PER_W-1:0] phase_q,
    output logic [PER_W-1:0] period_q
);
    logic [PER_W-1:0] period_req;

    assign period_req = PER_W'(period_cycles(32'(cks), 32'(brr)));
    assign wrap       = (phase_q == period_q - PER_W'(1));

    // The phase runs from reset on, so tick slots follow the running cycle count.
    // A new period is picked up only when the phase wraps.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            period_q <= period_req;
        end else if (wrap) begin
            phase_q  <= '0;
            period_q <= period_req;
        end else begin
            phase_q  <= phase_q + PER_W'(1);
        end
    end
endmodule

// File: rtl/baud_edge_sync.sv
module baud_edge_sync
    import baud_tick_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output pin_edge_t edges
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // The pin idles high, so the chain resets high.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[STAGES-1];
    end

    assign edges.rise = chain_q[STAGES-1] & ~last_q;
    assign edges.fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int CKS_W  = 2,
    parameter int BRR_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CKS_W-1:0] cks,
    input  logic [BRR_W-1:0] brr,
    input  logic             sync_mode,
    input  logic             cke1,
    input  logic             cke0,
    input  logic             ext_clk_in,
    input  logic             tx_active,
    input  logic             rx_active,
    output logic             tick,
    output logic [2:0]       clk_mode
);
    localparam int MAX_SHIFT = 1 + 2 * ((1 << CKS_W) - 1) + BRR_W;
    localparam int PER_W     = MAX_SHIFT + 1;

    clk_ctrl_t        ctrl;
    clk_mode_e        mode;
    logic             internal_src;
    logic             wrap;
    logic [PER_W-1:0] phase_q;
    logic [PER_W-1:0] period_q;
    pin_edge_t        edges;
    logic             want_tick;
    logic             tick_q;

    assign ctrl = '{sync_mode: sync_mode, cke1: cke1, cke0: cke0};

    baud_mode_decode u_dec (
        .ctrl         (ctrl),
        .mode         (mode),
        .internal_src (internal_src)
    );

    baud_rate_div #(.CKS_W(CKS_W), .BRR_W(BRR_W), .PER_W(PER_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .cks      (cks),
        .brr      (brr),
        .wrap     (wrap),
        .phase_q  (phase_q),
        .period_q (period_q)
    );

    baud_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_clk_in),
        .edges (edges)
    );

    always_comb begin
        if (internal_src)
            want_tick = wrap;
        else if (mode == CM_EXT_SYNC)
            want_tick = edges.rise | edges.fall;
        else
            want_tick = edges.rise;
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= want_tick & (tx_active | rx_active);
    end

    assign tick     = tick_q;
    assign clk_mode = mode;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
    parameter int PER_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [2:0]       mode_code,
    input logic             tx_active,
    input logic             rx_active,
    input logic [PER_W-1:0] phase,
    input logic [PER_W-1:0] period
);
    logic is_int;
    assign is_int = (mode_code == 3'd0) || (mode_code == 3'd1) || (mode_code == 3'd3);

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (rst)
        mode_code <= 3'd4);

    assert_phase_in_period_R2: assert property (@(posedge clk) disable iff (rst)
        phase < period);

    assert_idle_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !rx_active) |=> !tick);

    assert_single_cycle_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && is_int && $past(is_int)) |=> !tick);

    assert_tick_needs_request_R9: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(tx_active || rx_active));
endmodule

bind baud_tick_gen baud_tick_chk #(.PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode_code (clk_mode),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .phase     (phase_q),
    .period    (period_q)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cks = 2'd0;
    logic [7:0] brr = 8'd3;
    logic       sync_mode = 1'b0, cke1 = 1'b0, cke0 = 1'b0;
    logic       ext_clk_in = 1'b1;
    logic       tx_active = 1'b0, rx_active = 1'b0;
    logic       tick;
    logic [2:0] clk_mode;

    int    errors = 0, checks = 0, wd = 0;
    bit    chk_en = 1'b0, done = 1'b0;
    string cur_req = "R8";

    int k, nt;
    bit h1 = 1, h2 = 1, h3 = 1, exp_tick = 0;

    always #10 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst(rst), .cks(cks), .brr(brr),
        .sync_mode(sync_mode), .cke1(cke1), .cke0(cke0),
        .ext_clk_in(ext_clk_in), .tx_active(tx_active), .rx_active(rx_active),
        .tick(tick), .clk_mode(clk_mode)
    );

    function automatic int exp_period(int c, int b);
        int mult = 1;
        for (int i = 0; i < c; i++) mult = mult * 4;
        return 2 * mult * (b + 1);
    endfunction

    function automatic int exp_mode(bit s, bit e1, bit e0);
        if (s && e1) return 4;
        if (s) return 3;
        if (e1) return 2;
        if (e0) return 1;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at k=%0d", req, act, exp, k);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Model of the tick output, evaluated with the inputs seen before each edge.
    always @(posedge clk) begin
        if (rst) begin
            k = 0; nt = exp_period(cks, brr);
            h1 = 1; h2 = 1; h3 = 1; exp_tick = 0;
        end else begin
            int  m;
            bit  hit, pe;
            k++;
            m = exp_mode(sync_mode, cke1, cke0);
            hit = (k == nt);
            if (hit) nt = k + exp_period(cks, brr);
            pe = (m == 4) ? (h2 ^ h3) : (h2 & !h3);
            exp_tick = (tx_active || rx_active) && ((m == 2 || m == 4) ? pe : hit);
            h3 = h2; h2 = h1; h1 = ext_clk_in;
        end
    end

    always @(negedge clk) begin
        if (chk_en) check(cur_req, tick, exp_tick);
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        chk_en = 1'b0;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        chk_en = 1'b1;
    endtask

    task automatic pin_walk(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = ~ext_clk_in;
            cyc(1 + (i * 7) % 5);
        end
        cyc(6);
    endtask

    initial begin
        int brr_set[5] = '{0, 1, 2, 7, 255};
        cyc(3);
        check("R8", tick, 0);

        // R1: every combination of the three control bits
        for (int i = 0; i < 8; i++) begin
            {sync_mode, cke1, cke0} = 3'(i);
            #1;
            check("R1", clk_mode, exp_mode(sync_mode, cke1, cke0));
        end
        {sync_mode, cke1, cke0} = 3'b000;

        // R2 and R8: sweep of the period from reset
        cur_req = "R2";
        tx_active = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 5; b++) begin
                int p = exp_period(c, brr_set[b]);
                if (p <= 2048) begin
                    cks = 2'(c); brr = 8'(brr_set[b]);
                    do_reset();
                    cyc(3 * p + 4);
                end
            end
        end

        // R3 and R9: gating by the two requests, period 8
        cks = 2'd0; brr = 8'd3;
        do_reset();
        cur_req = "R9"; tx_active = 1; rx_active = 0; cyc(20);
        cur_req = "R3"; tx_active = 0; cyc(13);
        cur_req = "R9"; rx_active = 1; cyc(17);
        tx_active = 1; cyc(9);
        cur_req = "R3"; tx_active = 0; rx_active = 0; cyc(30);
        cur_req = "R9"; rx_active = 1; cyc(40);

        // R4: period changes while ticks are running
        cur_req = "R4"; tx_active = 1; rx_active = 0;
        cyc(5); brr = 8'd6; cyc(50);
        cks = 2'd1; brr = 8'd1; cyc(5);
        cks = 2'd0; brr = 8'd0; cyc(40);

        // R5 and R7: external asynchronous, internal period would tick every 2 cycles
        cur_req = "R5"; cke1 = 1; sync_mode = 0;
        pin_walk(40);
        // R6: external synchronous
        cur_req = "R6"; sync_mode = 1;
        pin_walk(40);
        // R7: pin ignored in internal modes
        cur_req = "R7"; cke1 = 0; cks = 2'd1; brr = 8'd2;
        pin_walk(30);
        sync_mode = 0; cke0 = 1;
        pin_walk(30);

        chk_en = 1'b0;
        finish_run();
    end
endmodule